// File: doc/BRIEF.md
# Translation Lookaside Buffer with Mixed Page Sizes

This block is a 64-entry, fully associative address translation cache for one access stream. Every cycle it may accept a lookup carrying a virtual address, a read/write flag, a privilege flag, an instruction/data flag and an access size. One cycle later it answers with a physical address or with a fault code. Each entry carries its own mapping size, which is one of four: 1 MB, 64 KB, 4 KB or 1 KB. The entry is compared only on the address bits above its own page offset.

When a lookup misses, the block reports a translation fault. An external table walker then writes the missing descriptor through the fill port. The fill lands in the slot named by a free-running pseudo-random counter. A single flush command empties the whole buffer. Each entry carries a domain number and an access-permission code. These are checked against a 16-domain access control word supplied as an input.

Top module: `tlb_xlate`

## Requirements
- R1: While rst_ni is low and after its release, rsp_valid_o, rsp_fault_o and rsp_pa_o are 0 and no entry is valid. The victim generator restarts from state 7'h01.
- R2: A lookup presented on a rising edge is answered on the next edge: rsp_valid_o equals the previous cycle's req_valid_i. The answer uses the contents as they were before that edge, so a fill or flush on the same edge does not affect it.
- R3: Size codes are 0 = 1 MB, 1 = 64 KB, 2 = 4 KB and 3 = 1 KB. An entry matches when the virtual address agrees with its stored virtual base on bits 31 down to 20, 16, 12 or 10 respectively. A clean hit returns fault 0. The returned physical address takes the stored physical base above that bit and the request's address bits below it.
- R4: A lookup with no matching valid entry, and no alignment fault, returns fault code 2 (translation).
- R5: The victim generator is a 7-bit shift register that advances on every clock as next = {s[5:0], s[6]^s[5]}. A fill with fill_valid_i high and flush_i low writes slot s[5:0] of the state current at that edge.
- R6: flush_i invalidates every entry in one edge. A flush takes priority over a fill on the same edge.
- R7: An alignment fault (code 1) is raised only for data accesses (req_data_i = 1). It is raised when req_size_i = 1 (half-word) and bit 0 is set, or when req_size_i is 2 or 3 (word) and bits 1:0 are non-zero. It takes priority over all other faults.
- R8: The entry's domain d selects dacr_i[2d+1:2d]. Value 2'b11 grants access without a permission check. Value 2'b01 requires the permission check. Values 2'b00 and 2'b10 give a domain fault (code 3).
- R9: Permission codes: 0 denies every access; 1 allows privileged accesses only; 2 allows privileged accesses and user reads; 3 allows everything. A denied access returns fault code 4.
- R10: When several valid entries match, the lowest-numbered slot supplies the translation and no error is raised.
- R11: Whenever rsp_fault_o is non-zero, or rsp_valid_o is low, rsp_pa_o is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous active-low reset |
| req_valid_i | input | 1 | Lookup request |
| req_va_i | input | 32 | Virtual address of lookup |
| req_write_i | input | 1 | 1 = write access |
| req_priv_i | input | 1 | 1 = privileged access |
| req_data_i | input | 1 | 1 = data access, 0 = instruction fetch |
| req_size_i | input | 2 | 0 byte, 1 half-word, 2/3 word |
| dacr_i | input | 32 | Two-bit access control per domain |
| fill_valid_i | input | 1 | Write a new entry |
| fill_vbase_i | input | 22 | Virtual address bits 31:10 of the entry |
| fill_pbase_i | input | 22 | Physical address bits 31:10 of the entry |
| fill_size_i | input | 2 | Mapping size code |
| fill_dom_i | input | 4 | Domain number |
| fill_ap_i | input | 2 | Access-permission code |
| flush_i | input | 1 | Invalidate all entries |
| rsp_valid_o | output | 1 | Response valid |
| rsp_fault_o | output | 3 | 0 none, 1 alignment, 2 translation, 3 domain, 4 permission |
| rsp_pa_o | output | 32 | Physical address on a clean hit |

## Verification
The hardest case to reach from the ports is a lookup that matches two live entries of different sizes. Fill slots are chosen by the pseudo-random generator, so only a cycle-accurate model of that generator can say which slot won. The bench fills a 1 MB section and a 1 KB page inside it, then looks up addresses both inside and outside the small page. It also mixes in hundreds of random fills over a few overlapping sections, so that evictions and multiple matches occur often. Same-edge fill/lookup and flush/fill pairs are driven on purpose to pin down the ordering rules.

// File: rtl/tlb_pkg.sv
package tlb_pkg;
  localparam int VA_W       = 32;
  localparam int PA_W       = 32;
  localparam int MIN_SHIFT  = 10;
  localparam int PN_W       = VA_W - MIN_SHIFT;
  localparam int DOM_W      = 4;
  localparam int AP_W       = 2;
  localparam int SECT_SHIFT = 20;
  localparam int LARGE_SHIFT = 16;
  localparam int SMALL_SHIFT = 12;

  typedef enum logic [1:0] {
    PG_SECTION = 2'd0,
    PG_LARGE   = 2'd1,
    PG_SMALL   = 2'd2,
    PG_TINY    = 2'd3
  } pg_size_e;

  typedef enum logic [2:0] {
    FLT_NONE   = 3'd0,
    FLT_ALIGN  = 3'd1,
    FLT_XLATE  = 3'd2,
    FLT_DOMAIN = 3'd3,
    FLT_PERM   = 3'd4
  } fault_e;

  typedef struct packed {
    logic [PN_W-1:0]  vpn;
    logic [PN_W-1:0]  ppn;
    pg_size_e         size;
    logic [DOM_W-1:0] dom;
    logic [AP_W-1:0]  ap;
  } tlb_entry_t;

  // bits of the page number that take part in the tag compare
  function automatic logic [PN_W-1:0] keep_mask(pg_size_e s);
    case (s)
      PG_SECTION: return {PN_W{1'b1}} << (SECT_SHIFT - MIN_SHIFT);
      PG_LARGE:   return {PN_W{1'b1}} << (LARGE_SHIFT - MIN_SHIFT);
      PG_SMALL:   return {PN_W{1'b1}} << (SMALL_SHIFT - MIN_SHIFT);
      default:    return {PN_W{1'b1}};
    endcase
  endfunction
endpackage

// File: rtl/tlb_lfsr.sv
module tlb_lfsr #(
  parameter int             W     = 7,
  parameter logic [W-1:0]   TAPS  = 7'h60,
  parameter int             IDX_W = 6
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  output logic [IDX_W-1:0] idx_o
);
  logic [W-1:0] state_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) state_q <= W'(1);
    else         state_q <= {state_q[W-2:0], ^(state_q & TAPS)};
  end

  assign idx_o = state_q[IDX_W-1:0];

  AST_LFSR_LIVE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    state_q != '0); // R5
endmodule

// File: rtl/tlb_entry_array.sv
module tlb_entry_array
  import tlb_pkg::*;
#(
  parameter int ENTRIES = 64,
  parameter int IDX_W   = $clog2(ENTRIES)
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             flush_i,
  input  logic             fill_i,
  input  logic [IDX_W-1:0] fill_idx_i,
  input  tlb_entry_t       fill_entry_i,
  input  logic [PN_W-1:0]  vpn_i,
  output logic             hit_o,
  output tlb_entry_t       hit_entry_o
);
  logic [ENTRIES-1:0] valid_q;
  logic [ENTRIES-1:0] match;
  tlb_entry_t         ent_q [ENTRIES];
  logic [IDX_W-1:0]   sel_idx;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      valid_q <= '0;
    end else if (flush_i) begin
      valid_q <= '0;
    end else if (fill_i) begin
      valid_q[fill_idx_i] <= 1'b1;
    end
  end

  always_ff @(posedge clk_i) begin
    if (fill_i && !flush_i) ent_q[fill_idx_i] <= fill_entry_i;
  end

  for (genvar gi = 0; gi < ENTRIES; gi++) begin : g_cmp
    assign match[gi] = valid_q[gi] &&
      (((ent_q[gi].vpn ^ vpn_i) & keep_mask(ent_q[gi].size)) == '0);
  end

  // lowest index wins
  always_comb begin
    sel_idx = '0;
    for (int i = ENTRIES - 1; i >= 0; i--) begin
      if (match[i]) sel_idx = IDX_W'(i);
    end
  end

  assign hit_o       = |match;
  assign hit_entry_o = ent_q[sel_idx];

  AST_FLUSH_EMPTY: assert property (@(posedge clk_i) disable iff (!rst_ni)
    flush_i |=> (valid_q == '0)); // R6
  AST_FILL_LANDS: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (fill_i && !flush_i) |=> valid_q[$past(fill_idx_i)]); // R5
endmodule

// File: rtl/tlb_access_check.sv
module tlb_access_check
  import tlb_pkg::*;
#(
  parameter int DOMAINS = 16
) (
  input  logic                 hit_i,
  input  tlb_entry_t           ent_i,
  input  logic [2*DOMAINS-1:0] dacr_i,
  input  logic                 priv_i,
  input  logic                 write_i,
  input  logic                 data_i,
  input  logic [1:0]           size_i,
  input  logic [1:0]           va_lo_i,
  output fault_e               fault_o
);
  logic       misalign;
  logic [1:0] dom_ctl;
  logic       perm_ok;

  assign misalign = data_i &&
    ((size_i == 2'd1 && va_lo_i[0]) || (size_i[1] && va_lo_i != 2'b00));
  assign dom_ctl  = dacr_i[ent_i.dom*2 +: 2];

  always_comb begin
    case (ent_i.ap)
      2'b00:   perm_ok = 1'b0;
      2'b01:   perm_ok = priv_i;
      2'b10:   perm_ok = priv_i || !write_i;
      default: perm_ok = 1'b1;
    endcase
  end

  always_comb begin
    if (misalign)                fault_o = FLT_ALIGN;
    else if (!hit_i)             fault_o = FLT_XLATE;
    else if (dom_ctl == 2'b11)   fault_o = FLT_NONE;
    else if (dom_ctl == 2'b01)   fault_o = perm_ok ? FLT_NONE : FLT_PERM;
    else                         fault_o = FLT_DOMAIN;
  end
endmodule

// File: rtl/tlb_xlate.sv
module tlb_xlate
  import tlb_pkg::*;
#(
  parameter int           ENTRIES   = 64,
  parameter int           DOMAINS   = 16,
  parameter int           LFSR_W    = 7,
  parameter logic [LFSR_W-1:0] LFSR_TAPS = 7'h60
) (
  input  logic                 clk_i,
  input  logic                 rst_ni,
  input  logic                 req_valid_i,
  input  logic [VA_W-1:0]      req_va_i,
  input  logic                 req_write_i,
  input  logic                 req_priv_i,
  input  logic                 req_data_i,
  input  logic [1:0]           req_size_i,
  input  logic [2*DOMAINS-1:0] dacr_i,
  input  logic                 fill_valid_i,
  input  logic [PN_W-1:0]      fill_vbase_i,
  input  logic [PN_W-1:0]      fill_pbase_i,
  input  logic [1:0]           fill_size_i,
  input  logic [DOM_W-1:0]     fill_dom_i,
  input  logic [AP_W-1:0]      fill_ap_i,
  input  logic                 flush_i,
  output logic                 rsp_valid_o,
  output logic [2:0]           rsp_fault_o,
  output logic [PA_W-1:0]      rsp_pa_o
);
  localparam int IDX_W = $clog2(ENTRIES);

  logic [IDX_W-1:0] victim;
  tlb_entry_t       fill_entry;
  tlb_entry_t       hit_entry;
  logic             hit;
  fault_e           fault;
  logic [PN_W-1:0]  keep;
  logic [PA_W-1:0]  pa_next;

  tlb_lfsr #(.W(LFSR_W), .TAPS(LFSR_TAPS), .IDX_W(IDX_W)) u_victim (
    .clk_i (clk_i),
    .rst_ni(rst_ni),
    .idx_o (victim)
  );

  assign fill_entry = '{vpn:  fill_vbase_i,
                        ppn:  fill_pbase_i,
                        size: pg_size_e'(fill_size_i),
                        dom:  fill_dom_i,
                        ap:   fill_ap_i};

  tlb_entry_array #(.ENTRIES(ENTRIES), .IDX_W(IDX_W)) u_array (
    .clk_i       (clk_i),
    .rst_ni      (rst_ni),
    .flush_i     (flush_i),
    .fill_i      (fill_valid_i),
    .fill_idx_i  (victim),
    .fill_entry_i(fill_entry),
    .vpn_i       (req_va_i[VA_W-1:MIN_SHIFT]),
    .hit_o       (hit),
    .hit_entry_o (hit_entry)
  );

  tlb_access_check #(.DOMAINS(DOMAINS)) u_check (
    .hit_i  (hit),
    .ent_i  (hit_entry),
    .dacr_i (dacr_i),
    .priv_i (req_priv_i),
    .write_i(req_write_i),
    .data_i (req_data_i),
    .size_i (req_size_i),
    .va_lo_i(req_va_i[1:0]),
    .fault_o(fault)
  );

  assign keep    = keep_mask(hit_entry.size);
  assign pa_next = {(hit_entry.ppn & keep) | (req_va_i[VA_W-1:MIN_SHIFT] & ~keep),
                    req_va_i[MIN_SHIFT-1:0]};

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      rsp_valid_o <= 1'b0;
      rsp_fault_o <= FLT_NONE;
      rsp_pa_o    <= '0;
    end else begin
      rsp_valid_o <= req_valid_i;
      rsp_fault_o <= req_valid_i ? fault : FLT_NONE;
      rsp_pa_o    <= (req_valid_i && fault == FLT_NONE) ? pa_next : '0;
    end
  end

  AST_RSP_FOLLOWS: assert property (@(posedge clk_i) disable iff (!rst_ni)
    req_valid_i |=> rsp_valid_o); // R2
  AST_RSP_IDLE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !req_valid_i |=> !rsp_valid_o); // R2
  AST_FAULT_NO_PA: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (rsp_fault_o != FLT_NONE || !rsp_valid_o) |-> (rsp_pa_o == '0)); // R11
  AST_FETCH_NO_ALIGN: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (req_valid_i && !req_data_i) |=> (rsp_fault_o != FLT_ALIGN)); // R7
  AST_MANAGER_PASS: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (req_valid_i && !req_data_i && hit && dacr_i[hit_entry.dom*2 +: 2] == 2'b11)
    |=> (rsp_fault_o == FLT_NONE)); // R8
  AST_FLUSH_MISSES: assert property (@(posedge clk_i) disable iff (!rst_ni)
    flush_i ##1 (req_valid_i && !req_data_i) |=> (rsp_fault_o == FLT_XLATE)); // R6
endmodule

// File: tb/tb_tlb_xlate.sv
module tb_tlb_xlate;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  always #5 clk = ~clk;

  logic        req_valid = 0, req_write = 0, req_priv = 0, req_data = 0;
  logic [31:0] req_va = '0;
  logic [1:0]  req_size = '0;
  logic [31:0] dacr = 32'h5555_558D; // d0=01 d1=11 d2=00 d3=10
  logic        fill_valid = 0, flush = 0;
  logic [31:0] fill_va = '0, fill_pa = '0;
  logic [1:0]  fill_size = '0, fill_ap = '0;
  logic [3:0]  fill_dom = '0;
  logic        rsp_valid;
  logic [2:0]  rsp_fault;
  logic [31:0] rsp_pa;

  tlb_xlate dut (
    .clk_i(clk), .rst_ni(rst_n),
    .req_valid_i(req_valid), .req_va_i(req_va), .req_write_i(req_write),
    .req_priv_i(req_priv), .req_data_i(req_data), .req_size_i(req_size),
    .dacr_i(dacr),
    .fill_valid_i(fill_valid), .fill_vbase_i(fill_va[31:10]),
    .fill_pbase_i(fill_pa[31:10]), .fill_size_i(fill_size),
    .fill_dom_i(fill_dom), .fill_ap_i(fill_ap), .flush_i(flush),
    .rsp_valid_o(rsp_valid), .rsp_fault_o(rsp_fault), .rsp_pa_o(rsp_pa)
  );

  int checks = 0, errors = 0;
  bit done = 0;
  string cur_tag = "R1", exp_tag = "R1";

  // reference model
  int       lf;
  bit       mv  [64];
  bit [31:0] mva [64];
  bit [31:0] mpa [64];
  bit [1:0] msz [64];
  bit [3:0] mdom[64];
  bit [1:0] map [64];
  bit       ev;
  int       ef;
  bit [31:0] ep;

  function automatic int shift_of(bit [1:0] s);
    case (s)
      2'd0: return 20;
      2'd1: return 16;
      2'd2: return 12;
      default: return 10;
    endcase
  endfunction

  always @(posedge clk) begin
    if (!rst_n) begin
      lf = 1; ev = 0; ef = 0; ep = 0;
      foreach (mv[i]) mv[i] = 0;
    end else begin
      int win;
      bit misal;
      ev = req_valid; ef = 0; ep = 0; exp_tag = cur_tag;
      if (req_valid) begin
        misal = req_data && ((req_size == 1 && req_va[0]) ||
                             (req_size >= 2 && req_va[1:0] != 0));
        win = -1;
        for (int i = 0; i < 64; i++)
          if (win < 0 && mv[i] && (req_va >> shift_of(msz[i])) == (mva[i] >> shift_of(msz[i])))
            win = i;
        if (misal) ef = 1;
        else if (win < 0) ef = 2;
        else begin
          bit [1:0] dc;
          bit ok;
          dc = dacr[2*mdom[win] +: 2];
          case (map[win])
            2'd0: ok = 0;
            2'd1: ok = req_priv;
            2'd2: ok = req_priv || !req_write;
            default: ok = 1;
          endcase
          if (dc == 2'b11) ef = 0;
          else if (dc == 2'b01) ef = ok ? 0 : 4;
          else ef = 3;
          if (ef == 0) begin
            int sh;
            sh = shift_of(msz[win]);
            ep = ((mpa[win] >> sh) << sh) | (req_va & ((32'h1 << sh) - 1));
          end
        end
      end
      if (flush) begin
        foreach (mv[i]) mv[i] = 0;
      end else if (fill_valid) begin
        int v;
        v = lf % 64;
        mv[v] = 1; mva[v] = fill_va; mpa[v] = fill_pa;
        msz[v] = fill_size; mdom[v] = fill_dom; map[v] = fill_ap;
      end
      lf = ((lf << 1) & 7'h7f) | (((lf >> 6) ^ (lf >> 5)) & 1);
    end
  end

  task automatic chk(bit ok, string tag, string what, longint act, longint exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s %s act=%0h exp=%0h at %0t", tag, what, act, exp, $time);
    end
  endtask

  function automatic string tag_of(int f);
    case (f)
      0: return "R3";
      1: return "R7";
      2: return "R4";
      3: return "R8";
      default: return "R9";
    endcase
  endfunction

  always @(negedge clk) begin
    if (!done) begin
      if (!rst_n) begin
        chk(rsp_valid == 0 && rsp_fault == 0 && rsp_pa == 0, "R1", "reset outputs",
            {rsp_valid, rsp_fault, rsp_pa}, 0);
      end else begin
        chk(rsp_valid == ev, {"R2/", exp_tag}, "rsp_valid", rsp_valid, ev);
        chk(rsp_fault == ef, {tag_of(ef), "/", exp_tag}, "fault", rsp_fault, ef);
        chk(rsp_pa == ep, {(ef != 0) ? "R11" : "R3", "/", exp_tag}, "pa", rsp_pa, ep);
      end
    end
  end

  task automatic drive(bit rv, bit [31:0] va, bit wr, bit pr, bit dt, bit [1:0] sz,
                       bit fv, bit [31:0] fva, bit [31:0] fpa, bit [1:0] fsz,
                       bit [3:0] fd, bit [1:0] fap, bit fl, string tag);
    @(negedge clk);
    req_valid = rv; req_va = va; req_write = wr; req_priv = pr; req_data = dt; req_size = sz;
    fill_valid = fv; fill_va = fva; fill_pa = fpa; fill_size = fsz; fill_dom = fd; fill_ap = fap;
    flush = fl; cur_tag = tag;
  endtask

  task automatic look(bit [31:0] va, bit wr, bit pr, bit dt, bit [1:0] sz, string tag);
    drive(1, va, wr, pr, dt, sz, 0, 0, 0, 0, 0, 0, 0, tag);
  endtask

  task automatic fill(bit [31:0] va, bit [31:0] pa, bit [1:0] sz, bit [3:0] d, bit [1:0] ap,
                      string tag);
    drive(0, 0, 0, 0, 0, 0, 1, va, pa, sz, d, ap, 0, tag);
  endtask

  task automatic idle(string tag);
    drive(0, 0, 0, 0, 0, 0, 0, 0, 0, 0, 0, 0, 0, tag);
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      done = 1;
      errors++; checks++;
      $display("FAIL watchdog expired");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1;
    idle("R1");
    look(32'h1234_5678, 0, 1, 0, 2, "R4");
    // R3: one mapping of each size
    fill(32'h1230_0000, 32'h8000_0000, 0, 0, 3, "R5");
    look(32'h123A_BCD8, 0, 0, 1, 2, "R3");
    fill(32'h2001_0000, 32'h9003_0000, 1, 0, 1, "R5");
    look(32'h2001_F004, 0, 1, 1, 2, "R3");
    look(32'h2001_F004, 0, 0, 1, 2, "R9");
    fill(32'h3000_5000, 32'hA000_7000, 2, 0, 2, "R5");
    look(32'h3000_5FFC, 0, 0, 1, 2, "R9");
    look(32'h3000_5FFC, 1, 0, 1, 2, "R9");
    look(32'h3000_5FFC, 1, 1, 1, 2, "R9");
    fill(32'h3000_6400, 32'hB000_0C00, 3, 0, 0, "R5");
    look(32'h3000_6404, 0, 1, 1, 2, "R9");
    look(32'h3000_6804, 0, 1, 1, 2, "R4");
    // R8: domain control values
    fill(32'h5000_0000, 32'hC000_0000, 0, 1, 0, "R8");
    look(32'h5000_1230, 1, 0, 1, 2, "R8");
    fill(32'h6000_0000, 32'hC010_0000, 0, 2, 3, "R8");
    look(32'h6000_0010, 0, 1, 0, 2, "R8");
    fill(32'h7000_0000, 32'hC020_0000, 0, 3, 3, "R8");
    look(32'h7000_0010, 0, 1, 0, 2, "R8");
    // R7: alignment
    look(32'hEEEE_0001, 0, 1, 1, 1, "R7");
    look(32'h1230_0002, 0, 1, 0, 2, "R7");
    look(32'h1230_0002, 0, 1, 1, 2, "R7");
    look(32'h1230_0003, 0, 1, 1, 0, "R7");
    look(32'h1230_0002, 0, 1, 1, 1, "R7");
    // R10: a 1 KB page inside a section, both live
    fill(32'h4000_0000, 32'h1000_0000, 0, 0, 3, "R10");
    fill(32'h4000_0400, 32'h2000_0000, 3, 0, 3, "R10");
    look(32'h4000_0404, 0, 1, 1, 2, "R10");
    look(32'h4000_0804, 0, 1, 1, 2, "R10");
    // R2: fill and lookup on the same edge
    drive(1, 32'h0900_0040, 0, 1, 1, 2, 1, 32'h0900_0000, 32'h0D00_0000, 2, 0, 3, 0, "R2");
    look(32'h0900_0040, 0, 1, 1, 2, "R2");
    // R6: flush wins over fill, lookup on flush edge sees old contents
    drive(1, 32'h1230_0000, 0, 1, 1, 2, 1, 32'h0A00_0000, 32'h0E00_0000, 0, 0, 3, 1, "R6");
    look(32'h1230_0000, 0, 1, 0, 2, "R6");
    look(32'h0A00_0000, 0, 1, 1, 2, "R6");
    // R5: random traffic over a few overlapping sections
    for (int n = 0; n < 600; n++) begin
      int op;
      bit [31:0] va, fva;
      op  = $urandom % 100;
      va  = {12'h0A0 + 12'($urandom % 3), 20'($urandom)};
      fva = {12'h0A0 + 12'($urandom % 3), 20'($urandom)};
      if (op < 3) dacr = $urandom;
      if (op < 40)
        look(va, 1'($urandom), 1'($urandom), 1'($urandom), 2'($urandom), "R5");
      else if (op < 65)
        fill(fva, $urandom, 2'($urandom), 4'($urandom), 2'($urandom), "R5");
      else if (op < 88)
        drive(1, va, 1'($urandom), 1'($urandom), 0, 2, 1, fva, $urandom,
              2'($urandom), 4'($urandom % 4), 2'($urandom), 0, "R5");
      else if (op < 91)
        drive(1, va, 0, 1, 0, 2, 0, 0, 0, 0, 0, 0, 1, "R6");
      else if (op < 94)
        drive(0, 0, 0, 0, 0, 0, 1, fva, $urandom, 0, 0, 3, 1, "R6");
      else
        idle("R5");
    end
    drive(0, 0, 0, 0, 0, 0, 0, 0, 0, 0, 0, 0, 1, "R6");
    look(32'h0A01_0000, 0, 1, 0, 2, "R6");
    idle("R6");
    idle("R6");
    @(negedge clk);
    done = 1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule